// File: doc/BRIEF.md
# Prioritised Interrupt Entry Sequencer

This block is the interrupt-entry engine of a small communications processor. It collects interrupt requests from five sources: a supervisor call, a program/machine check split into a high-urgency and a low-urgency group, an interval timer, up to six I/O B channels and the single I/O A channel. It holds the current program status word (PSW), and each mask bit in that word decides whether its source may interrupt. When a request is selected, the block runs an entry sequence on its memory port. The sequence saves the running PSW and writes the interrupt code and status halfwords to fixed low-memory slots. It then fetches the handler's PSW from a vector slot and makes that PSW current.

The new PSW's mask bits gate the very next arbitration. Several entry sequences can therefore run back to back before any instruction executes. Because each sequence saves the PSW loaded by the one before it, the handlers unwind in the reverse order of selection. A resume input, driven by the PSW-load instruction, puts a saved PSW back while the block is idle. Request inputs are single-cycle pulses, and each one stays pending inside the block until it is served.

The memory side is a valid/ready request stream. Once `mem_valid` is high, the address, write flag, write data and halfword strobes stay frozen until a cycle in which `mem_ready` is also high. That cycle completes the transfer. The memory may hold `mem_ready` low for any number of cycles, and the sequencer simply waits. For reads, `mem_rdata` must be valid in the cycle in which `mem_ready` is high.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset the PSW is all zeros, `busy` is low and `mem_valid` is low.
- R2: An entry sequence makes exactly four transfers, in this order:
  - a full-word store of the current PSW to the return slot (status slot + 4), strobe 11;
  - a store of the code halfword to the status slot, in data bits 15:0, strobe 01;
  - a store of the status halfword to the status slot, in data bits 31:16, strobe 10;
  - a read of the class's vector slot, whose word becomes the PSW.
- R3: Status slots are 0x58 for supervisor call, 0x60 for both check groups, 0x50 for the timer, 0x48 for I/O B and 0x40 for I/O A.
  - Vector slots are NEW_PSW_BASE plus 0 for the check groups, +4 for the timer, +8 for I/O B, +12 for I/O A and +16 for supervisor call.
  - Among eligible requests the selection order is: high check group, timer, I/O B (lowest channel first), I/O A, low check group.
- R4: PSW bits are numbered from the most significant end (bit i is `psw[31-i]`), and mask bit Mi is PSW bit i.
  - M0 enables I/O A, M1 to M6 enable I/O B channels 1 to 6, and M7 enables the timer.
  - A masked request starts no sequence and leaves the PSW unchanged.
- R5: Check requests ignore the mask bits. After a check sequence loads its PSW, further check requests wait until a resume.
- R6: The mask bits of a newly loaded PSW apply to the very next arbitration.
- R7: The I/O B code halfword, numbered from its most significant bit, is laid out as follows:
  - bit 0 is 0;
  - bits 1-3 hold the channel type;
  - bit 4 is 0;
  - bits 5-7 hold the channel number (1 to 6);
  - bits 8-15 hold the device address.
  - The status halfword is the value presented by that channel.
- R8: The timer and I/O A codes are zero, and the error flag of each appears as the least significant status bit. Check requests store their presented code and a zero status. A supervisor call stores {8'h00, argument} and a zero status.
- R9: A pending supervisor call is taken ahead of all other requests and ignores the mask bits.
- R10: A request stays pending until its vector read completes, so a masked request is served once a later PSW enables it.
- R11: While `mem_valid` is high and `mem_ready` is low, every memory request field holds its value.
- R12: A resume pulse while idle makes the resume word the PSW and ends the check-handler hold. A resume pulse that arrives in the same cycle as a pending request wins, and arbitration waits one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| svc_req | input | 1 | Supervisor call request pulse |
| svc_arg | input | 8 | Supervisor call register-field argument |
| pmch_req | input | 1 | High-urgency check request (address, protection, parity) |
| pmch_code | input | 16 | Code for the high-urgency check |
| pmcl_req | input | 1 | Low-urgency check request (power, invalid operation and similar) |
| pmcl_code | input | 16 | Code for the low-urgency check |
| tmr_req | input | 1 | Interval timer request pulse |
| tmr_perr | input | 1 | Timer word parity error flag |
| ioa_req | input | 1 | I/O A request pulse |
| ioa_err | input | 1 | I/O A list store error flag |
| iob_req | input | NCH | I/O B request pulses; bit k is channel k+1 |
| iob_type | input | 3*NCH | Channel type per channel |
| iob_dev | input | 8*NCH | Device address per channel |
| iob_stat | input | 16*NCH | Status halfword per channel |
| resume_valid | input | 1 | PSW restore pulse |
| resume_psw | input | 32 | PSW to restore |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wstrb | output | 2 | Halfword strobes: bit 1 = data 31:16, bit 0 = data 15:0 |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| psw | output | 32 | Current program status word |
| busy | output | 1 | Entry sequence in progress |

## Verification
The bench builds the block with its default parameters: six I/O B channels, a 10-bit byte address and vector slots from 0x70. With six channels, every mask bit M0 to M7 and the full 3-bit channel-number field can be exercised, as can the ordering among several channels pending at once. The 0x70 vector base keeps the vector slots apart from the slots the sequencer writes. The bench can therefore preload handler PSWs whose masks chain one sequence into the next, or that block it, with random ready stalls on every transfer.

// File: rtl/ies_pkg.sv
package ies_pkg;
  localparam int DEV_W = 8;
  localparam int HW_W  = 16;
  localparam int TYP_W = 3;

  typedef enum logic [2:0] {
    CL_SVC  = 3'd0,
    CL_PMCH = 3'd1,
    CL_TMR  = 3'd2,
    CL_IOB  = 3'd3,
    CL_IOA  = 3'd4,
    CL_PMCL = 3'd5
  } icls_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RET  = 3'd1,
    S_CODE = 3'd2,
    S_STAT = 3'd3,
    S_NEW  = 3'd4
  } seq_st_e;

  // Byte address of the status/code word for a class; return PSW sits 4 above.
  function automatic logic [7:0] stat_slot(input icls_e c);
    case (c)
      CL_SVC:  stat_slot = 8'h58;
      CL_TMR:  stat_slot = 8'h50;
      CL_IOB:  stat_slot = 8'h48;
      CL_IOA:  stat_slot = 8'h40;
      default: stat_slot = 8'h60;
    endcase
  endfunction

  // Word index of the vector PSW above the configurable base.
  function automatic logic [2:0] vec_idx(input icls_e c);
    case (c)
      CL_TMR:  vec_idx = 3'd1;
      CL_IOB:  vec_idx = 3'd2;
      CL_IOA:  vec_idx = 3'd3;
      CL_SVC:  vec_idx = 3'd4;
      default: vec_idx = 3'd0;
    endcase
  endfunction

  function automatic logic is_check(input icls_e c);
    is_check = (c == CL_PMCH) || (c == CL_PMCL);
  endfunction
endpackage

// File: rtl/ies_pending.sv
module ies_pending
  import ies_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int CH_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  svc_req,
  input  logic [7:0]            svc_arg,
  input  logic                  pmch_req,
  input  logic [HW_W-1:0]       pmch_code,
  input  logic                  pmcl_req,
  input  logic [HW_W-1:0]       pmcl_code,
  input  logic                  tmr_req,
  input  logic                  tmr_perr,
  input  logic                  ioa_req,
  input  logic                  ioa_err,
  input  logic [NCH-1:0]        iob_req,
  input  logic [NCH*TYP_W-1:0]  iob_type,
  input  logic [NCH*DEV_W-1:0]  iob_dev,
  input  logic [NCH*HW_W-1:0]   iob_stat,
  input  logic                  clr_valid,
  input  icls_e                 clr_cls,
  input  logic [CH_W-1:0]       clr_chan,
  output logic                  p_svc,
  output logic [7:0]            q_svc_arg,
  output logic                  p_pmch,
  output logic [HW_W-1:0]       q_pmch_code,
  output logic                  p_pmcl,
  output logic [HW_W-1:0]       q_pmcl_code,
  output logic                  p_tmr,
  output logic                  q_tmr_perr,
  output logic                  p_ioa,
  output logic                  q_ioa_err,
  output logic [NCH-1:0]        p_iob,
  output logic [NCH*TYP_W-1:0]  q_iob_type,
  output logic [NCH*DEV_W-1:0]  q_iob_dev,
  output logic [NCH*HW_W-1:0]   q_iob_stat
);
  logic c_svc, c_pmch, c_pmcl, c_tmr, c_ioa, c_iob;

  always_comb begin
    c_svc  = clr_valid && (clr_cls == CL_SVC);
    c_pmch = clr_valid && (clr_cls == CL_PMCH);
    c_pmcl = clr_valid && (clr_cls == CL_PMCL);
    c_tmr  = clr_valid && (clr_cls == CL_TMR);
    c_ioa  = clr_valid && (clr_cls == CL_IOA);
    c_iob  = clr_valid && (clr_cls == CL_IOB);
  end

  // A new pulse wins over a same-cycle clear, so it is never lost.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_svc       <= 1'b0;
      q_svc_arg   <= '0;
      p_pmch      <= 1'b0;
      q_pmch_code <= '0;
      p_pmcl      <= 1'b0;
      q_pmcl_code <= '0;
      p_tmr       <= 1'b0;
      q_tmr_perr  <= 1'b0;
      p_ioa       <= 1'b0;
      q_ioa_err   <= 1'b0;
      p_iob       <= '0;
      q_iob_type  <= '0;
      q_iob_dev   <= '0;
      q_iob_stat  <= '0;
    end else begin
      p_svc  <= (p_svc  & ~c_svc)  | svc_req;
      p_pmch <= (p_pmch & ~c_pmch) | pmch_req;
      p_pmcl <= (p_pmcl & ~c_pmcl) | pmcl_req;
      p_tmr  <= (p_tmr  & ~c_tmr)  | tmr_req;
      p_ioa  <= (p_ioa  & ~c_ioa)  | ioa_req;
      if (svc_req)  q_svc_arg   <= svc_arg;
      if (pmch_req) q_pmch_code <= pmch_code;
      if (pmcl_req) q_pmcl_code <= pmcl_code;
      if (tmr_req)  q_tmr_perr  <= tmr_perr;
      if (ioa_req)  q_ioa_err   <= ioa_err;
      for (int k = 0; k < NCH; k++) begin
        p_iob[k] <= (p_iob[k] & ~(c_iob && (clr_chan == CH_W'(k)))) | iob_req[k];
        if (iob_req[k]) begin
          q_iob_type[k*TYP_W +: TYP_W] <= iob_type[k*TYP_W +: TYP_W];
          q_iob_dev[k*DEV_W +: DEV_W]  <= iob_dev[k*DEV_W +: DEV_W];
          q_iob_stat[k*HW_W +: HW_W]   <= iob_stat[k*HW_W +: HW_W];
        end
      end
    end
  end
endmodule

// File: rtl/ies_arbiter.sv
module ies_arbiter
  import ies_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int CH_W = 3
) (
  input  logic                  p_svc,
  input  logic [7:0]            q_svc_arg,
  input  logic                  p_pmch,
  input  logic [HW_W-1:0]       q_pmch_code,
  input  logic                  p_pmcl,
  input  logic [HW_W-1:0]       q_pmcl_code,
  input  logic                  p_tmr,
  input  logic                  q_tmr_perr,
  input  logic                  p_ioa,
  input  logic                  q_ioa_err,
  input  logic [NCH-1:0]        p_iob,
  input  logic [NCH*TYP_W-1:0]  q_iob_type,
  input  logic [NCH*DEV_W-1:0]  q_iob_dev,
  input  logic [NCH*HW_W-1:0]   q_iob_stat,
  input  logic [31:0]           psw,
  input  logic                  in_pmc,
  output logic                  sel_valid,
  output icls_e                 sel_cls,
  output logic [CH_W-1:0]       sel_chan,
  output logic [HW_W-1:0]       sel_code,
  output logic [HW_W-1:0]       sel_stat
);
  logic            iob_hit;
  logic [CH_W-1:0] iob_k;
  logic [2:0]      iob_num;

  // Lowest-numbered enabled channel; channel k+1 is gated by mask bit psw[30-k].
  always_comb begin
    iob_hit = 1'b0;
    iob_k   = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (p_iob[k] && psw[30-k]) begin
        iob_hit = 1'b1;
        iob_k   = CH_W'(k);
      end
    end
    iob_num = 3'(int'(iob_k) + 1);
  end

  always_comb begin
    sel_valid = 1'b1;
    sel_cls   = CL_SVC;
    sel_chan  = '0;
    sel_code  = '0;
    sel_stat  = '0;
    if (p_svc) begin
      sel_code = {8'h00, q_svc_arg};
    end else if (p_pmch && !in_pmc) begin
      sel_cls  = CL_PMCH;
      sel_code = q_pmch_code;
    end else if (p_tmr && psw[24]) begin
      sel_cls  = CL_TMR;
      sel_stat = {15'd0, q_tmr_perr};
    end else if (iob_hit) begin
      sel_cls  = CL_IOB;
      sel_chan = iob_k;
      sel_code = {1'b0, q_iob_type[iob_k*TYP_W +: TYP_W], 1'b0, iob_num,
                  q_iob_dev[iob_k*DEV_W +: DEV_W]};
      sel_stat = q_iob_stat[iob_k*HW_W +: HW_W];
    end else if (p_ioa && psw[31]) begin
      sel_cls  = CL_IOA;
      sel_stat = {15'd0, q_ioa_err};
    end else if (p_pmcl && !in_pmc) begin
      sel_cls  = CL_PMCL;
      sel_code = q_pmcl_code;
    end else begin
      sel_valid = 1'b0;
    end
  end
endmodule

// File: rtl/ies_engine.sv
module ies_engine
  import ies_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int NEW_PSW_BASE = 'h70,
  parameter int CH_W         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  input  icls_e             sel_cls,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic [HW_W-1:0]   sel_code,
  input  logic [HW_W-1:0]   sel_stat,
  input  logic              resume_valid,
  input  logic [31:0]       resume_psw,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_wstrb,
  output logic [31:0]       mem_wdata,
  output logic [31:0]       psw,
  output logic              in_pmc,
  output logic              busy,
  output logic              start,
  output logic              clr_valid,
  output icls_e             clr_cls,
  output logic [CH_W-1:0]   clr_chan
);
  seq_st_e         st;
  icls_e           cur_cls;
  logic [CH_W-1:0] cur_chan;
  logic [HW_W-1:0] cur_code, cur_stat;
  logic [ADDR_W-1:0] stat_a, ret_a, vec_a;
  logic xfer;

  assign start = (st == S_IDLE) && !resume_valid && sel_valid;
  assign busy  = (st != S_IDLE);
  assign xfer  = mem_valid && mem_ready;

  always_comb begin
    stat_a = ADDR_W'(stat_slot(cur_cls));
    ret_a  = stat_a + ADDR_W'(4);
    vec_a  = ADDR_W'(NEW_PSW_BASE + 4 * int'(vec_idx(cur_cls)));
  end

  // Request fields derive only from registered state, so they hold while stalled.
  always_comb begin
    mem_valid = 1'b1;
    mem_we    = 1'b1;
    mem_addr  = stat_a;
    mem_wstrb = 2'b00;
    mem_wdata = '0;
    case (st)
      S_RET:  begin mem_addr = ret_a; mem_wstrb = 2'b11; mem_wdata = psw; end
      S_CODE: begin mem_wstrb = 2'b01; mem_wdata = {16'h0000, cur_code}; end
      S_STAT: begin mem_wstrb = 2'b10; mem_wdata = {cur_stat, 16'h0000}; end
      S_NEW:  begin mem_we = 1'b0; mem_addr = vec_a; end
      default: begin mem_valid = 1'b0; mem_we = 1'b0; mem_addr = '0; end
    endcase
  end

  assign clr_valid = (st == S_NEW) && xfer;
  assign clr_cls   = cur_cls;
  assign clr_chan  = cur_chan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      psw      <= '0;
      in_pmc   <= 1'b0;
      cur_cls  <= CL_SVC;
      cur_chan <= '0;
      cur_code <= '0;
      cur_stat <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (resume_valid) begin
            psw    <= resume_psw;
            in_pmc <= 1'b0;
          end else if (sel_valid) begin
            cur_cls  <= sel_cls;
            cur_chan <= sel_chan;
            cur_code <= sel_code;
            cur_stat <= sel_stat;
            st       <= S_RET;
          end
        end
        S_RET:  if (xfer) st <= S_CODE;
        S_CODE: if (xfer) st <= S_STAT;
        S_STAT: if (xfer) st <= S_NEW;
        S_NEW: begin
          if (xfer) begin
            psw <= mem_rdata;
            if (is_check(cur_cls)) in_pmc <= 1'b1;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import ies_pkg::*;
#(
  parameter int NCH          = 6,
  parameter int ADDR_W       = 10,
  parameter int NEW_PSW_BASE = 'h70
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 svc_req,
  input  logic [7:0]           svc_arg,
  input  logic                 pmch_req,
  input  logic [15:0]          pmch_code,
  input  logic                 pmcl_req,
  input  logic [15:0]          pmcl_code,
  input  logic                 tmr_req,
  input  logic                 tmr_perr,
  input  logic                 ioa_req,
  input  logic                 ioa_err,
  input  logic [NCH-1:0]       iob_req,
  input  logic [3*NCH-1:0]     iob_type,
  input  logic [8*NCH-1:0]     iob_dev,
  input  logic [16*NCH-1:0]    iob_stat,
  input  logic                 resume_valid,
  input  logic [31:0]          resume_psw,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [1:0]           mem_wstrb,
  output logic [31:0]          mem_wdata,
  input  logic [31:0]          mem_rdata,
  output logic [31:0]          psw,
  output logic                 busy
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic                 p_svc, p_pmch, p_pmcl, p_tmr, p_ioa;
  logic [7:0]           q_svc_arg;
  logic [HW_W-1:0]      q_pmch_code, q_pmcl_code;
  logic                 q_tmr_perr, q_ioa_err;
  logic [NCH-1:0]       p_iob;
  logic [NCH*TYP_W-1:0] q_iob_type;
  logic [NCH*DEV_W-1:0] q_iob_dev;
  logic [NCH*HW_W-1:0]  q_iob_stat;
  logic                 sel_valid, in_pmc, start, clr_valid;
  icls_e                sel_cls, clr_cls;
  logic [CH_W-1:0]      sel_chan, clr_chan;
  logic [HW_W-1:0]      sel_code, sel_stat;

  ies_pending #(.NCH(NCH), .CH_W(CH_W)) pend_i (
    .clk(clk), .rst_n(rst_n),
    .svc_req(svc_req), .svc_arg(svc_arg),
    .pmch_req(pmch_req), .pmch_code(pmch_code),
    .pmcl_req(pmcl_req), .pmcl_code(pmcl_code),
    .tmr_req(tmr_req), .tmr_perr(tmr_perr),
    .ioa_req(ioa_req), .ioa_err(ioa_err),
    .iob_req(iob_req), .iob_type(iob_type), .iob_dev(iob_dev), .iob_stat(iob_stat),
    .clr_valid(clr_valid), .clr_cls(clr_cls), .clr_chan(clr_chan),
    .p_svc(p_svc), .q_svc_arg(q_svc_arg),
    .p_pmch(p_pmch), .q_pmch_code(q_pmch_code),
    .p_pmcl(p_pmcl), .q_pmcl_code(q_pmcl_code),
    .p_tmr(p_tmr), .q_tmr_perr(q_tmr_perr),
    .p_ioa(p_ioa), .q_ioa_err(q_ioa_err),
    .p_iob(p_iob), .q_iob_type(q_iob_type), .q_iob_dev(q_iob_dev), .q_iob_stat(q_iob_stat)
  );

  ies_arbiter #(.NCH(NCH), .CH_W(CH_W)) arb_i (
    .p_svc(p_svc), .q_svc_arg(q_svc_arg),
    .p_pmch(p_pmch), .q_pmch_code(q_pmch_code),
    .p_pmcl(p_pmcl), .q_pmcl_code(q_pmcl_code),
    .p_tmr(p_tmr), .q_tmr_perr(q_tmr_perr),
    .p_ioa(p_ioa), .q_ioa_err(q_ioa_err),
    .p_iob(p_iob), .q_iob_type(q_iob_type), .q_iob_dev(q_iob_dev), .q_iob_stat(q_iob_stat),
    .psw(psw), .in_pmc(in_pmc),
    .sel_valid(sel_valid), .sel_cls(sel_cls), .sel_chan(sel_chan),
    .sel_code(sel_code), .sel_stat(sel_stat)
  );

  ies_engine #(.ADDR_W(ADDR_W), .NEW_PSW_BASE(NEW_PSW_BASE), .CH_W(CH_W)) eng_i (
    .clk(clk), .rst_n(rst_n),
    .sel_valid(sel_valid), .sel_cls(sel_cls), .sel_chan(sel_chan),
    .sel_code(sel_code), .sel_stat(sel_stat),
    .resume_valid(resume_valid), .resume_psw(resume_psw),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata),
    .psw(psw), .in_pmc(in_pmc), .busy(busy), .start(start),
    .clr_valid(clr_valid), .clr_cls(clr_cls), .clr_chan(clr_chan)
  );
endmodule

// File: rtl/ies_chk.sv
module ies_chk
  import ies_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_wstrb,
  input logic [31:0]       mem_wdata,
  input logic [31:0]       psw,
  input logic              busy,
  input logic              resume_valid,
  input logic              start,
  input icls_e             start_cls,
  input logic [CH_W-1:0]   start_chan,
  input logic              in_pmc
);
  logic load_done;
  assign load_done = mem_valid && mem_ready && !mem_we;

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata) && $stable(mem_wstrb));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  a_r2_first_is_ret: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> mem_valid && mem_we && (mem_wstrb == 2'b11) && (mem_wdata == $past(psw)));

  a_r4_tmr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    start && (start_cls == CL_TMR) |-> psw[24]);

  a_r4_ioa_gate: assert property (@(posedge clk) disable iff (!rst_n)
    start && (start_cls == CL_IOA) |-> psw[31]);

  a_r4_iob_gate: assert property (@(posedge clk) disable iff (!rst_n)
    start && (start_cls == CL_IOB) |-> psw[30 - int'(start_chan)]);

  a_r5_check_hold: assert property (@(posedge clk) disable iff (!rst_n)
    start && ((start_cls == CL_PMCH) || (start_cls == CL_PMCL)) |-> !in_pmc);

  a_r12_psw_source: assert property (@(posedge clk) disable iff (!rst_n)
    (psw != $past(psw)) |-> $past(load_done) || $past(resume_valid && !busy));
endmodule

bind intr_entry_seq ies_chk #(.ADDR_W(ADDR_W), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata),
  .psw(psw), .busy(busy), .resume_valid(resume_valid),
  .start(start), .start_cls(sel_cls), .start_chan(sel_chan), .in_pmc(in_pmc)
);

// File: tb/intr_entry_seq_tb_top.sv
module intr_entry_seq_tb_top;
  localparam int NCH = 6;
  localparam int AW  = 10;
  localparam int LOG = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic svc_req = 0, pmch_req = 0, pmcl_req = 0, tmr_req = 0, tmr_perr = 0;
  logic ioa_req = 0, ioa_err = 0, resume_valid = 0;
  logic [7:0] svc_arg = 0;
  logic [15:0] pmch_code = 0, pmcl_code = 0;
  logic [NCH-1:0] iob_req = 0;
  logic [3*NCH-1:0] iob_type = 0;
  logic [8*NCH-1:0] iob_dev = 0;
  logic [16*NCH-1:0] iob_stat = 0;
  logic [31:0] resume_psw = 0;
  logic mem_valid, mem_we, busy;
  logic mem_ready = 0;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_wstrb;
  logic [31:0] mem_wdata, psw;
  logic [31:0] mem_rdata = 0;

  intr_entry_seq #(.NCH(NCH), .ADDR_W(AW), .NEW_PSW_BASE('h70)) dut_i (
    .clk(clk), .rst_n(rst_n), .svc_req(svc_req), .svc_arg(svc_arg),
    .pmch_req(pmch_req), .pmch_code(pmch_code), .pmcl_req(pmcl_req), .pmcl_code(pmcl_code),
    .tmr_req(tmr_req), .tmr_perr(tmr_perr), .ioa_req(ioa_req), .ioa_err(ioa_err),
    .iob_req(iob_req), .iob_type(iob_type), .iob_dev(iob_dev), .iob_stat(iob_stat),
    .resume_valid(resume_valid), .resume_psw(resume_psw),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .psw(psw), .busy(busy));

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:255];
  logic [44:0] lg [0:LOG-1];
  int lg_n = 0, lg_base = 0;

  // Memory responder with random stalls; each completed transfer is logged.
  always @(negedge clk) begin
    if (!rst_n) mem_ready = 1'b0;
    else begin
      mem_ready = ($urandom % 4) != 0;
      mem_rdata = mem[mem_addr[9:2]];
      if (mem_valid && mem_ready) begin
        lg[lg_n % LOG] = {mem_we, mem_wstrb, mem_addr, mem_we ? mem_wdata : 32'h0};
        lg_n++;
      end
    end
  end

  // Reference model state
  logic [31:0] m_psw = 0;
  logic m_inpmc = 0, m_svc = 0, m_pmch = 0, m_pmcl = 0, m_tmr = 0, m_ioa = 0;
  logic [7:0] m_svc_arg;
  logic [15:0] m_pmch_code, m_pmcl_code;
  logic m_tmr_perr, m_ioa_err;
  logic [NCH-1:0] m_iob = 0;
  logic [2:0] m_typ [NCH];
  logic [7:0] m_dev [NCH];
  logic [15:0] m_st [NCH];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] b_stat(input int c);
    case (c)
      0: b_stat = 10'h58; 2: b_stat = 10'h50; 3: b_stat = 10'h48;
      4: b_stat = 10'h40; default: b_stat = 10'h60;
    endcase
  endfunction

  function automatic logic [9:0] b_vec(input int c);
    case (c)
      2: b_vec = 10'h74; 3: b_vec = 10'h78; 4: b_vec = 10'h7C;
      0: b_vec = 10'h80; default: b_vec = 10'h70;
    endcase
  endfunction

  task automatic settle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (!busy) q++; else q = 0;
    end
  endtask

  // Applies current drive values to the model, holds them one cycle, clears pulses.
  task automatic commit();
    lg_base = lg_n;
    if (resume_valid) begin m_psw = resume_psw; m_inpmc = 1'b0; end
    if (svc_req) begin m_svc = 1; m_svc_arg = svc_arg; end
    if (pmch_req) begin m_pmch = 1; m_pmch_code = pmch_code; end
    if (pmcl_req) begin m_pmcl = 1; m_pmcl_code = pmcl_code; end
    if (tmr_req) begin m_tmr = 1; m_tmr_perr = tmr_perr; end
    if (ioa_req) begin m_ioa = 1; m_ioa_err = ioa_err; end
    for (int k = 0; k < NCH; k++)
      if (iob_req[k]) begin
        m_iob[k] = 1; m_typ[k] = iob_type[k*3 +: 3];
        m_dev[k] = iob_dev[k*8 +: 8]; m_st[k] = iob_stat[k*16 +: 16];
      end
    @(negedge clk);
    svc_req = 0; pmch_req = 0; pmcl_req = 0; tmr_req = 0; ioa_req = 0;
    iob_req = '0; resume_valid = 0;
  endtask

  task automatic chk_tx(input string req, input int idx, input logic [44:0] exp);
    logic [44:0] act;
    act = (idx < lg_n) ? lg[idx % LOG] : 45'h0;
    chk(req, {19'h0, act}, {19'h0, exp});
  endtask

  // Replays the expected sequences from the model and compares them with the log.
  task automatic drain_check(input string tag);
    int idx = lg_base;
    int c, ch;
    logic [15:0] code, stat;
    string ctag;
    logic go = 1;
    while (go) begin
      c = -1; ch = 0; code = 0; stat = 0;
      if (m_svc) begin c = 0; code = {8'h0, m_svc_arg}; end
      else if (m_pmch && !m_inpmc) begin c = 1; code = m_pmch_code; end
      else if (m_tmr && m_psw[24]) begin c = 2; stat = {15'h0, m_tmr_perr}; end
      else begin
        for (int k = NCH - 1; k >= 0; k--) if (m_iob[k] && m_psw[30-k]) begin c = 3; ch = k; end
        if (c == 3) begin
          code = {1'b0, m_typ[ch], 1'b0, 3'(ch + 1), m_dev[ch]}; stat = m_st[ch];
        end else if (m_ioa && m_psw[31]) begin c = 4; stat = {15'h0, m_ioa_err}; end
        else if (m_pmcl && !m_inpmc) begin c = 5; code = m_pmcl_code; end
      end
      if (c < 0) go = 0;
      else begin
        ctag = (c == 3) ? "R7" : "R8";
        chk_tx(tag, idx, {1'b1, 2'b11, b_stat(c) + 10'd4, m_psw});
        chk_tx(ctag, idx + 1, {1'b1, 2'b01, b_stat(c), 16'h0, code});
        chk_tx(ctag, idx + 2, {1'b1, 2'b10, b_stat(c), stat, 16'h0});
        chk_tx("R2", idx + 3, {1'b0, 2'b00, b_vec(c), 32'h0});
        idx += 4;
        m_psw = mem[b_vec(c) >> 2];
        case (c)
          0: m_svc = 0; 1: m_pmch = 0; 2: m_tmr = 0;
          3: m_iob[ch] = 0; 4: m_ioa = 0; default: m_pmcl = 0;
        endcase
        if (c == 1 || c == 5) m_inpmc = 1;
      end
    end
    chk(tag, 64'(lg_n - lg_base), 64'(idx - lg_base));
    chk(tag, {32'h0, psw}, {32'h0, m_psw});
  endtask

  task automatic do_resume(input logic [31:0] v, input string tag);
    resume_psw = v; resume_valid = 1;
    commit();
    settle();
    drain_check(tag);
  endtask

  task automatic set_vectors(input logic [7:0] mp, input logic [7:0] mt,
                             input logic [7:0] mb, input logic [7:0] ma, input logic [7:0] ms);
    mem['h70 >> 2] = {mp, 24'h00_1100};
    mem['h74 >> 2] = {mt, 24'h10_2200};
    mem['h78 >> 2] = {mb, 24'h21_3300};
    mem['h7C >> 2] = {ma, 24'h32_4400};
    mem['h80 >> 2] = {ms, 24'h03_5500};
  endtask

  task automatic rand_data();
    svc_arg = 8'($urandom); pmch_code = 16'($urandom); pmcl_code = 16'($urandom);
    tmr_perr = 1'($urandom); ioa_err = 1'($urandom);
    for (int k = 0; k < NCH; k++) begin
      iob_type[k*3 +: 3] = 3'($urandom); iob_dev[k*8 +: 8] = 8'($urandom);
      iob_stat[k*16 +: 16] = 16'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {32'h0, psw}, 64'h0);
    chk("R1", {63'h0, busy}, 64'h0);
    chk("R1", {63'h0, mem_valid}, 64'h0);

    // R12: resume loads PSW
    do_resume(32'hFF00_1234, "R12");

    // R3: everything at once, all vectors fully enabled; low check held (R5)
    set_vectors(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    rand_data();
    pmch_req = 1; pmcl_req = 1; tmr_req = 1; ioa_req = 1; iob_req = '1;
    commit(); settle(); drain_check("R3");
    chk("R11", 64'(lg_n - lg_base), 64'd36);
    do_resume(32'hFF00_0000, "R5");

    // R4: masked sources do nothing, then R10: served after enabling
    do_resume(32'h0000_0000, "R12");
    rand_data();
    tmr_req = 1; ioa_req = 1; iob_req = 6'b000010;
    commit(); settle(); drain_check("R4");
    chk("R4", 64'(lg_n - lg_base), 64'd0);
    do_resume(32'hFF00_0000, "R10");

    // R6: timer handler's PSW disables I/O A, so it waits
    set_vectors(8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00);
    rand_data();
    tmr_req = 1; ioa_req = 1;
    commit(); settle(); drain_check("R6");
    do_resume(32'h8000_0000, "R10");

    // R9 and R5: supervisor call first, check taken with all masks off
    do_resume(32'h0000_0000, "R12");
    rand_data();
    svc_req = 1; pmch_req = 1; tmr_req = 1;
    commit(); settle(); drain_check("R9");
    do_resume(32'h0100_0000, "R5");

    // R3 randomized mixes
    for (int it = 0; it < 40; it++) begin
      set_vectors(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      do_resume({8'($urandom), 24'($urandom)}, "R12");
      rand_data();
      svc_req = ($urandom % 4) == 0; pmch_req = ($urandom % 4) == 0;
      pmcl_req = ($urandom % 4) == 0; tmr_req = 1'($urandom);
      ioa_req = 1'($urandom); iob_req = 6'($urandom);
      commit(); settle(); drain_check("R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule